// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer and Select Decoder

This block sits between a processor whose low address bits share pins with its 16-bit data word and a board that wants a plain, separated address bus and data bus. While the address-latch strobe is high, the block captures the bus into a latched address register. Once the strobe drops, it holds that address for the rest of the cycle. It also steers data through a bidirectional buffer. The direction follows the processor's transmit/receive line, and the buffer works only while the active-low data-enable is low.

From the held address, the block decodes the selects for the rest of the board. There are four active-low peripheral selects, taken from a three-bit field. There is one active-low configuration ROM select for I/O cycles, taken from the two top bits of the low 16. There is also a one-of-eight RAM device-pair select for memory cycles, and the index of the 128 KB block that the pair belongs to. During an interrupt acknowledge, the block answers the processor with a fixed vector word whose low byte is all ones.

Every output is registered once against the block clock, with a synchronous active-high reset. Each output therefore reflects the inputs present at the preceding rising edge.

Top module: `busdemux_top`

## Requirements
- R1: At a rising edge where `ale_i` is 1, `lat_addr_o` takes the value of `mux_bus_i`. At a rising edge where `ale_i` is 0, `lat_addr_o` keeps its value, whatever is on the bus.
- R2: At an edge with `data_en_n_i`=0, `dir_tx_i`=1 and `iack_n_i`=1, the block does three things. It sets `lat_data_oe_o` to 1, it copies the low 16 bits of `mux_bus_i` into `lat_data_o`, and it clears `cpu_data_oe_o` to 0.
- R3: At an edge with `data_en_n_i`=0, `dir_tx_i`=0 and `iack_n_i`=1, the block sets `cpu_data_oe_o` to 1, copies `lat_data_i` into `cpu_data_o`, and clears `lat_data_oe_o` to 0.
- R4: With `data_en_n_i`=1 and `iack_n_i`=1, neither output enable is set. The two enables are never 1 together.
- R5: While `ale_i` is 0, address bits 7:5 select a peripheral. Code 0 drives `periph_cs_n_o[0]` low (serial loop), code 1 drives bit 1 low (power manager), code 2 drives bit 2 low (keyboard) and code 3 drives bit 3 low (display registers). Codes 4 to 7 drive no select. While `ale_i` is 1, every select is high.
- R6: `rom_cs_n_o` goes low only when `ale_i`=0, `mem_cycle_i`=0 and address bits 15:14 are 2'b11.
- R7: When `ale_i`=0, `mem_cycle_i`=1 and address bit 19 is 0, the block drives exactly one select low: `ram_pair_cs_n_o[addr[18:16]]`. It also sets `ram_block_o` to addr[18:17]. Otherwise every pair select is high and `ram_block_o` is 0.
- R8: At an edge with `iack_n_i`=0, `cpu_data_o` becomes 16'h00FF and `cpu_data_oe_o` becomes 1, and `lat_data_oe_o` becomes 0. This holds whatever `data_en_n_i` and `dir_tx_i` are.
- R9: One edge with `rst` high puts the block in its reset state. All selects go high, both enables go 0, and the latched address goes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| mux_bus_i | input | 20 | Multiplexed bus; the low 16 bits also carry write data |
| ale_i | input | 1 | Address-latch strobe, high during the address phase |
| dir_tx_i | input | 1 | 1 = processor transmits, 0 = processor receives |
| data_en_n_i | input | 1 | Data buffer enable, active low |
| mem_cycle_i | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| iack_n_i | input | 1 | Interrupt acknowledge, active low |
| lat_data_i | input | 16 | Data returned from the latched data bus |
| lat_addr_o | output | 20 | Latched address bus |
| lat_data_o | output | 16 | Write data toward the latched data bus |
| lat_data_oe_o | output | 1 | Drive enable for `lat_data_o` |
| cpu_data_o | output | 16 | Read data or vector toward the processor |
| cpu_data_oe_o | output | 1 | Drive enable for `cpu_data_o` |
| periph_cs_n_o | output | 4 | Peripheral selects, active low |
| rom_cs_n_o | output | 1 | Configuration ROM select, active low |
| ram_pair_cs_n_o | output | 8 | RAM device-pair selects, active low |
| ram_block_o | output | 2 | 128 KB block index of the selected pair |

## Verification
The bound checker watches several properties on every clock. It checks that the latch is transparent under the strobe and stable without it. It checks that both buffer directions respond to their controls, that the two drive enables never meet, and that the peripheral and RAM selects are one-hot-or-none. It also checks that every select stays quiet during the address phase and that the acknowledge vector overrides the buffer controls. Some behaviours only the bench's scenarios can show. These are the exact code-to-pin map of the peripheral and RAM decoders, the unused codes and the out-of-region RAM addresses, and the ROM match together with its address field. They also include the block index grouping and a reset applied in the middle of an active access.

// File: rtl/busdemux_pkg.sv
package busdemux_pkg;

  // Direction chosen for the data buffer in a given cycle.
  typedef enum logic [1:0] {
    STEER_IDLE   = 2'd0,
    STEER_TO_LAT = 2'd1,
    STEER_TO_CPU = 2'd2,
    STEER_IACK   = 2'd3
  } steer_e;

  // Acknowledge wins over everything. Then the enable gates the buffer,
  // and the transmit line picks the direction.
  function automatic steer_e pick_steer(input logic en_n, input logic tx,
                                        input logic iack_n);
    steer_e s;
    if (!iack_n)  s = STEER_IACK;
    else if (en_n) s = STEER_IDLE;
    else if (tx)   s = STEER_TO_LAT;
    else           s = STEER_TO_CPU;
    return s;
  endfunction

endpackage

// File: rtl/busdemux_addr_latch.sv
module busdemux_addr_latch #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale_i,
  input  logic [ADDR_W-1:0] bus_i,
  output logic [ADDR_W-1:0] addr_next_o,
  output logic [ADDR_W-1:0] addr_q_o
);

  logic [ADDR_W-1:0] addr_q;

  // Pass-through value while the strobe is high, held value otherwise.
  always_comb addr_next_o = ale_i ? bus_i : addr_q;

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= addr_next_o;
  end

  assign addr_q_o = addr_q;

endmodule

// File: rtl/busdemux_io_decode.sv
module busdemux_io_decode #(
  parameter int              PSEL_W   = 3,
  parameter int              N_PERIPH = 4,
  parameter int              ROM_W    = 2,
  parameter logic [ROM_W-1:0] ROM_CODE = '1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ale_i,
  input  logic                mem_cycle_i,
  input  logic [PSEL_W-1:0]   psel_i,
  input  logic [ROM_W-1:0]    romf_i,
  output logic [N_PERIPH-1:0] periph_cs_n_o,
  output logic                rom_cs_n_o
);

  logic [N_PERIPH-1:0] per_hit;
  logic                rom_hit;

  // One comparator per peripheral; codes at or above N_PERIPH match nothing.
  for (genvar g = 0; g < N_PERIPH; g++) begin : g_per
    always_comb per_hit[g] = !ale_i && (psel_i == PSEL_W'(g));
  end

  always_comb rom_hit = !ale_i && !mem_cycle_i && (romf_i == ROM_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      periph_cs_n_o <= '1;
      rom_cs_n_o    <= 1'b1;
    end else begin
      periph_cs_n_o <= ~per_hit;
      rom_cs_n_o    <= ~rom_hit;
    end
  end

endmodule

// File: rtl/busdemux_ram_select.sv
module busdemux_ram_select #(
  parameter int HI_W   = 4,
  parameter int PAIR_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ale_i,
  input  logic                   mem_cycle_i,
  input  logic [HI_W-1:0]        hi_i,
  output logic [(1<<PAIR_W)-1:0] pair_cs_n_o,
  output logic [PAIR_W-2:0]      block_o
);

  localparam int N_PAIRS = 1 << PAIR_W;

  logic [PAIR_W-1:0]  pair;
  logic               region_ok;
  logic               hit;
  logic [N_PAIRS-1:0] pair_sel;

  always_comb begin
    pair      = hi_i[PAIR_W-1:0];
    region_ok = (hi_i[HI_W-1:PAIR_W] == '0);
    hit       = !ale_i && mem_cycle_i && region_ok;
  end

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    always_comb pair_sel[p] = hit && (pair == PAIR_W'(p));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_cs_n_o <= '1;
      block_o     <= '0;
    end else begin
      pair_cs_n_o <= ~pair_sel;
      // Two neighbouring pairs share one block.
      block_o     <= hit ? pair[PAIR_W-1:1] : '0;
    end
  end

endmodule

// File: rtl/busdemux_data_steer.sv
module busdemux_data_steer
  import busdemux_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bus_i,
  input  logic [DATA_W-1:0] lat_data_i,
  input  logic              en_n_i,
  input  logic              tx_i,
  input  logic              iack_n_i,
  output logic [DATA_W-1:0] lat_data_o,
  output logic              lat_data_oe_o,
  output logic [DATA_W-1:0] cpu_data_o,
  output logic              cpu_data_oe_o
);

  localparam logic [DATA_W-1:0] IACK_WORD = {{(DATA_W-8){1'b0}}, 8'hFF};

  steer_e            steer;
  logic [DATA_W-1:0] lat_d, cpu_d;
  logic              lat_oe_d, cpu_oe_d;

  always_comb begin
    steer    = pick_steer(en_n_i, tx_i, iack_n_i);
    lat_d    = '0;
    cpu_d    = '0;
    lat_oe_d = 1'b0;
    cpu_oe_d = 1'b0;
    case (steer)
      STEER_TO_LAT: begin lat_d = bus_i;      lat_oe_d = 1'b1; end
      STEER_TO_CPU: begin cpu_d = lat_data_i; cpu_oe_d = 1'b1; end
      STEER_IACK:   begin cpu_d = IACK_WORD;  cpu_oe_d = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_data_o    <= '0;
      lat_data_oe_o <= 1'b0;
      cpu_data_o    <= '0;
      cpu_data_oe_o <= 1'b0;
    end else begin
      lat_data_o    <= lat_d;
      lat_data_oe_o <= lat_oe_d;
      cpu_data_o    <= cpu_d;
      cpu_data_oe_o <= cpu_oe_d;
    end
  end

endmodule

// File: rtl/busdemux_top.sv
module busdemux_top #(
  parameter int               ADDR_W   = 20,
  parameter int               DATA_W   = 16,
  parameter int               PSEL_LSB = 5,
  parameter int               PSEL_W   = 3,
  parameter int               N_PERIPH = 4,
  parameter int               ROM_LSB  = 14,
  parameter int               ROM_W    = 2,
  parameter logic [ROM_W-1:0] ROM_CODE = '1,
  parameter int               PAIR_LSB = 16,
  parameter int               PAIR_W   = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      mux_bus_i,
  input  logic                   ale_i,
  input  logic                   dir_tx_i,
  input  logic                   data_en_n_i,
  input  logic                   mem_cycle_i,
  input  logic                   iack_n_i,
  input  logic [DATA_W-1:0]      lat_data_i,
  output logic [ADDR_W-1:0]      lat_addr_o,
  output logic [DATA_W-1:0]      lat_data_o,
  output logic                   lat_data_oe_o,
  output logic [DATA_W-1:0]      cpu_data_o,
  output logic                   cpu_data_oe_o,
  output logic [N_PERIPH-1:0]    periph_cs_n_o,
  output logic                   rom_cs_n_o,
  output logic [(1<<PAIR_W)-1:0] ram_pair_cs_n_o,
  output logic [PAIR_W-2:0]      ram_block_o
);

  localparam int HI_W = ADDR_W - PAIR_LSB;

  logic [ADDR_W-1:0] addr_next;

  busdemux_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk         (clk),
    .rst         (rst),
    .ale_i       (ale_i),
    .bus_i       (mux_bus_i),
    .addr_next_o (addr_next),
    .addr_q_o    (lat_addr_o)
  );

  busdemux_io_decode #(
    .PSEL_W   (PSEL_W),
    .N_PERIPH (N_PERIPH),
    .ROM_W    (ROM_W),
    .ROM_CODE (ROM_CODE)
  ) u_io (
    .clk           (clk),
    .rst           (rst),
    .ale_i         (ale_i),
    .mem_cycle_i   (mem_cycle_i),
    .psel_i        (addr_next[PSEL_LSB +: PSEL_W]),
    .romf_i        (addr_next[ROM_LSB +: ROM_W]),
    .periph_cs_n_o (periph_cs_n_o),
    .rom_cs_n_o    (rom_cs_n_o)
  );

  busdemux_ram_select #(.HI_W(HI_W), .PAIR_W(PAIR_W)) u_ram (
    .clk         (clk),
    .rst         (rst),
    .ale_i       (ale_i),
    .mem_cycle_i (mem_cycle_i),
    .hi_i        (addr_next[ADDR_W-1:PAIR_LSB]),
    .pair_cs_n_o (ram_pair_cs_n_o),
    .block_o     (ram_block_o)
  );

  busdemux_data_steer #(.DATA_W(DATA_W)) u_steer (
    .clk           (clk),
    .rst           (rst),
    .bus_i         (mux_bus_i[DATA_W-1:0]),
    .lat_data_i    (lat_data_i),
    .en_n_i        (data_en_n_i),
    .tx_i          (dir_tx_i),
    .iack_n_i      (iack_n_i),
    .lat_data_o    (lat_data_o),
    .lat_data_oe_o (lat_data_oe_o),
    .cpu_data_o    (cpu_data_o),
    .cpu_data_oe_o (cpu_data_oe_o)
  );

endmodule

// File: rtl/busdemux_chk.sv
module busdemux_chk #(
  parameter int               ADDR_W   = 20,
  parameter int               DATA_W   = 16,
  parameter int               PSEL_LSB = 5,
  parameter int               PSEL_W   = 3,
  parameter int               N_PERIPH = 4,
  parameter int               ROM_LSB  = 14,
  parameter int               ROM_W    = 2,
  parameter logic [ROM_W-1:0] ROM_CODE = '1,
  parameter int               PAIR_LSB = 16,
  parameter int               PAIR_W   = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic [ADDR_W-1:0]      mux_bus_i,
  input logic                   ale_i,
  input logic                   dir_tx_i,
  input logic                   data_en_n_i,
  input logic                   mem_cycle_i,
  input logic                   iack_n_i,
  input logic [DATA_W-1:0]      lat_data_i,
  input logic [ADDR_W-1:0]      lat_addr_o,
  input logic [DATA_W-1:0]      lat_data_o,
  input logic                   lat_data_oe_o,
  input logic [DATA_W-1:0]      cpu_data_o,
  input logic                   cpu_data_oe_o,
  input logic [N_PERIPH-1:0]    periph_cs_n_o,
  input logic                   rom_cs_n_o,
  input logic [(1<<PAIR_W)-1:0] ram_pair_cs_n_o,
  input logic [PAIR_W-2:0]      ram_block_o
);

  p_latch_pass_r1: assert property (@(posedge clk) disable iff (rst)
    ale_i |=> lat_addr_o == $past(mux_bus_i));

  p_latch_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !ale_i |=> $stable(lat_addr_o));

  p_write_path_r2: assert property (@(posedge clk) disable iff (rst)
    (!data_en_n_i && dir_tx_i && iack_n_i)
      |=> lat_data_oe_o && lat_data_o == $past(mux_bus_i[DATA_W-1:0]));

  p_read_path_r3: assert property (@(posedge clk) disable iff (rst)
    (!data_en_n_i && !dir_tx_i && iack_n_i)
      |=> cpu_data_oe_o && cpu_data_o == $past(lat_data_i));

  p_no_contention_r4: assert property (@(posedge clk) disable iff (rst)
    !(lat_data_oe_o && cpu_data_oe_o));

  p_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (data_en_n_i && iack_n_i) |=> !lat_data_oe_o && !cpu_data_oe_o);

  p_periph_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~periph_cs_n_o));

  p_addr_phase_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    ale_i |=> (&periph_cs_n_o) && rom_cs_n_o && (&ram_pair_cs_n_o));

  p_rom_io_only_r6: assert property (@(posedge clk) disable iff (rst)
    mem_cycle_i |=> rom_cs_n_o);

  p_ram_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ram_pair_cs_n_o));

  p_ram_mem_only_r7: assert property (@(posedge clk) disable iff (rst)
    !mem_cycle_i |=> &ram_pair_cs_n_o);

  p_ram_block_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (&ram_pair_cs_n_o) |-> ram_block_o == '0);

  p_iack_vector_r8: assert property (@(posedge clk) disable iff (rst)
    !iack_n_i |=> cpu_data_oe_o && cpu_data_o[7:0] == 8'hFF && !lat_data_oe_o);

  p_reset_state_r9: assert property (@(posedge clk)
    rst |=> (&periph_cs_n_o) && rom_cs_n_o && (&ram_pair_cs_n_o)
            && !lat_data_oe_o && !cpu_data_oe_o && lat_addr_o == '0);

endmodule

bind busdemux_top busdemux_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .PSEL_LSB (PSEL_LSB),
  .PSEL_W   (PSEL_W),
  .N_PERIPH (N_PERIPH),
  .ROM_LSB  (ROM_LSB),
  .ROM_W    (ROM_W),
  .ROM_CODE (ROM_CODE),
  .PAIR_LSB (PAIR_LSB),
  .PAIR_W   (PAIR_W)
) u_chk (.*);

// File: tb/busdemux_top_bench.sv
`timescale 1ns/1ps
module busdemux_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] mux_bus_i = '0;
  logic        ale_i = 1'b0;
  logic        dir_tx_i = 1'b0;
  logic        data_en_n_i = 1'b1;
  logic        mem_cycle_i = 1'b0;
  logic        iack_n_i = 1'b1;
  logic [15:0] lat_data_i = '0;
  logic [19:0] lat_addr_o;
  logic [15:0] lat_data_o;
  logic        lat_data_oe_o;
  logic [15:0] cpu_data_o;
  logic        cpu_data_oe_o;
  logic [3:0]  periph_cs_n_o;
  logic        rom_cs_n_o;
  logic [7:0]  ram_pair_cs_n_o;
  logic [1:0]  ram_block_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  busdemux_top u_busdemux_top (.*);

  // Fields: [33] mem cycle, [32:13] address, [12:9] peripheral selects,
  // [8] ROM select, [7:0] RAM pair selects.
  localparam int NV = 15;
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 20'h00000, 4'b1110, 1'b1, 8'hFF},
    {1'b0, 20'h00020, 4'b1101, 1'b1, 8'hFF},
    {1'b0, 20'h00040, 4'b1011, 1'b1, 8'hFF},
    {1'b0, 20'h00060, 4'b0111, 1'b1, 8'hFF},
    {1'b0, 20'h00080, 4'b1111, 1'b1, 8'hFF},
    {1'b0, 20'h000E0, 4'b1111, 1'b1, 8'hFF},
    {1'b0, 20'h0C0A0, 4'b1111, 1'b0, 8'hFF},
    {1'b0, 20'h080A0, 4'b1111, 1'b1, 8'hFF},
    {1'b0, 20'hF4020, 4'b1101, 1'b1, 8'hFF},
    {1'b1, 20'h30080, 4'b1111, 1'b1, 8'hF7},
    {1'b1, 20'h70080, 4'b1111, 1'b1, 8'h7F},
    {1'b1, 20'h00080, 4'b1111, 1'b1, 8'hFE},
    {1'b1, 20'h80080, 4'b1111, 1'b1, 8'hFF},
    {1'b1, 20'h4C080, 4'b1111, 1'b1, 8'hEF},
    {1'b1, 20'h2C060, 4'b0111, 1'b1, 8'hFB}
  };

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic quiet_selects(input string tag);
    check(tag, {28'd0, periph_cs_n_o}, 32'hF);
    check(tag, {31'd0, rom_cs_n_o}, 32'h1);
    check(tag, {24'd0, ram_pair_cs_n_o}, 32'hFF);
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R9: held in reset, the all-zero address would otherwise select peripheral 0.
    quiet_selects("R9 reset selects");
    check("R9 reset lat_addr", {12'd0, lat_addr_o}, 32'h0);
    check("R9 reset oe", {30'd0, lat_data_oe_o, cpu_data_oe_o}, 32'h0);
    rst = 1'b0;
    tick();

    for (int i = 0; i < NV; i++) begin
      logic [19:0] a;
      logic [1:0]  blk;
      a = VEC[i][32:13];
      blk = (VEC[i][7:0] != 8'hFF) ? a[18:17] : 2'b00;
      mem_cycle_i = VEC[i][33];
      ale_i = 1'b1;
      mux_bus_i = a;
      tick();
      check("R1 transparent", {12'd0, lat_addr_o}, {12'd0, a});
      quiet_selects("R5 address phase");
      ale_i = 1'b0;
      mux_bus_i = ~a;
      tick();
      check("R1 hold", {12'd0, lat_addr_o}, {12'd0, a});
      check("R5 periph decode", {28'd0, periph_cs_n_o}, {28'd0, VEC[i][12:9]});
      check("R6 rom decode", {31'd0, rom_cs_n_o}, {31'd0, VEC[i][8]});
      check("R7 ram pair", {24'd0, ram_pair_cs_n_o}, {24'd0, VEC[i][7:0]});
      check("R7 ram block", {30'd0, ram_block_o}, {30'd0, blk});
    end

    // R1: strobe high over two cycles follows the bus each cycle.
    ale_i = 1'b1; mux_bus_i = 20'h12345; tick();
    check("R1 follow 1", {12'd0, lat_addr_o}, 32'h12345);
    mux_bus_i = 20'hABCDE; tick();
    check("R1 follow 2", {12'd0, lat_addr_o}, 32'hABCDE);
    ale_i = 1'b0;

    // R2: write toward the latched side.
    mux_bus_i = 20'h51234; data_en_n_i = 1'b0; dir_tx_i = 1'b1; tick();
    check("R2 write data", {16'd0, lat_data_o}, 32'h1234);
    check("R2 write oe", {30'd0, lat_data_oe_o, cpu_data_oe_o}, 32'h2);

    // R3: read toward the processor.
    dir_tx_i = 1'b0; lat_data_i = 16'hBEEF; tick();
    check("R3 read data", {16'd0, cpu_data_o}, 32'hBEEF);
    check("R3 read oe", {30'd0, lat_data_oe_o, cpu_data_oe_o}, 32'h1);

    // R4: enable high drives nothing.
    data_en_n_i = 1'b1; dir_tx_i = 1'b1; tick();
    check("R4 idle oe", {30'd0, lat_data_oe_o, cpu_data_oe_o}, 32'h0);

    // R8: acknowledge with buffer disabled, then with a write requested.
    iack_n_i = 1'b0; tick();
    check("R8 vector", {16'd0, cpu_data_o}, 32'h00FF);
    check("R8 oe", {30'd0, lat_data_oe_o, cpu_data_oe_o}, 32'h1);
    data_en_n_i = 1'b0; dir_tx_i = 1'b1; tick();
    check("R8 override vector", {16'd0, cpu_data_o}, 32'h00FF);
    check("R8 override oe", {30'd0, lat_data_oe_o, cpu_data_oe_o}, 32'h1);
    iack_n_i = 1'b1; data_en_n_i = 1'b1;

    // R9: reset during an active memory and write access.
    ale_i = 1'b1; mem_cycle_i = 1'b1; mux_bus_i = 20'h20020; tick();
    ale_i = 1'b0; data_en_n_i = 1'b0; dir_tx_i = 1'b1; tick();
    check("R7 pre-reset pair", {24'd0, ram_pair_cs_n_o}, 32'hFB);
    rst = 1'b1; tick();
    quiet_selects("R9 mid reset");
    check("R9 mid reset oe", {30'd0, lat_data_oe_o, cpu_data_oe_o}, 32'h0);
    check("R9 mid reset addr", {12'd0, lat_addr_o}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule